// File: doc/BRIEF.md
# Self-Steering Omega Packet Switch

An eight-port packet switch built from three columns of two-by-two switching elements. Every input line passes through a fixed perfect-shuffle wiring ahead of each column, and each element forwards a packet to its upper or lower output by reading a single bit of the packet's 3-bit destination tag. No routing table or central scheduler exists: the tag alone steers the packet through the fabric to the output port whose index equals the tag.

Each input offers at most one packet per cycle: a valid bit, a destination tag and a payload word. When two packets reach an element and both ask for the same output, the packet on the element's upper input goes through and the other is dropped for that cycle. Its source port sees a blocked flag and must offer the packet again later. Packets with different destinations can still collide this way inside the fabric. The routing through all three columns is combinational, and one register stage at the edge holds the delivered packets, each with its source port number, and the blocked flags. Results therefore appear one clock after the packets are offered.

Top module: `omega_route_net`

## Requirements
- R1: While reset is asserted, and in the cycle after it, every output valid bit and every blocked flag reads 0.
- R2: A packet offered on input port s with tag t that is not blocked appears one cycle later on output port t with valid 1, source field s and its payload unchanged.
- R3: Column c (c = 0, 1, 2) reads tag bit 2-c, so the most significant bit is read first. A bit value of 0 selects the element's upper output and 1 selects the lower one. A lone packet from port 4 to tag 6 (binary 110) goes lower, lower, then upper, and arrives at output 6.
- R4: Ahead of each column, line i feeds line position rotl3(i), which is a 3-bit rotation left by one. As a result, every cyclic shift pattern (port i to tag (i+k) mod 8, all ports valid) passes all eight packets with no blocking.
- R5: When both inputs of an element request the same output, the packet on the upper input (the even line) wins and the packet on the lower input is blocked.
- R6: Two packets with different tags still block when they meet in one element and share the tag bit read there. For example, port 0 to tag 0 and port 4 to tag 1 meet in column 0 at element 0, and port 4 is blocked.
- R7: Inputs whose valid bit is 0 take no part in routing or arbitration. An output that carries no packet shows valid 0 with zero source and payload fields.
- R8: One cycle after packets are offered, the blocked flag is set exactly for the valid inputs whose packets were dropped. The number of valid outputs plus the number of set blocked flags equals the number of valid inputs. A blocked packet offered again without its competitor is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 8 | Packet valid per input port |
| in_dest | input | 24 | 3-bit destination tag per input port, port i at bits [3i+2:3i] |
| in_data | input | 64 | 8-bit payload per input port, port i at bits [8i+7:8i] |
| out_vld | output | 8 | Packet valid per output port, registered |
| out_src | output | 24 | Source port of the packet on each output, port j at bits [3j+2:3j] |
| out_data | output | 64 | Payload on each output, port j at bits [8j+7:8j] |
| in_blk | output | 8 | Blocked flag per input port for the packets offered in the previous cycle |

## Verification
The assertions assume that the inputs are stable around each rising edge and that every routing decision depends only on the input values captured at the previous edge. They compare each delivered packet against a registered copy of those inputs. They also assume that no packet may be lost silently, so every valid input must show up either at an output or as a blocked flag. The stimulus follows this by changing inputs only on falling edges. It offers at most one packet per port per cycle and leaves reset released for the whole traffic phase. It exercises the named collision cases, every cyclic shift pattern, a retry sequence, and a long run of pseudo-random valid masks and tags.

// File: rtl/omega_pkg.sv
package omega_pkg;

    typedef enum logic {
        PORT_UP = 1'b0,
        PORT_DN = 1'b1
    } port_sel_e;

    // Perfect shuffle on an aw-bit line index: rotate left by one bit.
    function automatic int shuffle_pos(input int idx, input int aw);
        int mask;
        mask = (1 << aw) - 1;
        return ((idx << 1) | (idx >> (aw - 1))) & mask;
    endfunction

endpackage

// File: rtl/omega_elem.sv
// One 2x2 element. A packet is {vld, dst[A], src[A], dat[W]}.
module omega_elem #(
    parameter int A      = 3,
    parameter int W      = 8,
    parameter int BITSEL = 2,
    localparam int PW    = 1 + 2 * A + W
) (
    input  logic [PW-1:0] pk_up,
    input  logic [PW-1:0] pk_dn,
    output logic [PW-1:0] q_up,
    output logic [PW-1:0] q_dn,
    output logic          lose,
    output logic [A-1:0]  lose_src
);
    import omega_pkg::*;

    localparam int DST_LSB = W + A;

    port_sel_e want_up;
    port_sel_e want_dn;
    logic      v_up;
    logic      v_dn;

    always_comb begin
        v_up    = pk_up[PW-1];
        v_dn    = pk_dn[PW-1];
        want_up = port_sel_e'(pk_up[DST_LSB+BITSEL]);
        want_dn = port_sel_e'(pk_dn[DST_LSB+BITSEL]);
        q_up    = '0;
        q_dn    = '0;
        // Lower input placed first, upper input overrides on a tie.
        if (v_dn) begin
            if (want_dn == PORT_DN) q_dn = pk_dn;
            else                    q_up = pk_dn;
        end
        if (v_up) begin
            if (want_up == PORT_DN) q_dn = pk_up;
            else                    q_up = pk_up;
        end
        lose     = v_up && v_dn && (want_up == want_dn);
        lose_src = pk_dn[W +: A];
    end

endmodule

// File: rtl/omega_stage.sv
// Shuffle wiring followed by one column of elements.
module omega_stage #(
    parameter int A   = 3,
    parameter int W   = 8,
    parameter int STG = 0,
    localparam int N  = 1 << A,
    localparam int PW = 1 + 2 * A + W,
    localparam int NE = N / 2
) (
    input  logic [N*PW-1:0] lines_i,
    output logic [N*PW-1:0] lines_o,
    output logic [N-1:0]    blk_o
);
    logic [N*PW-1:0] shuf;
    logic [NE-1:0]   lose;
    logic [A-1:0]    lose_src [NE];

    for (genvar i = 0; i < N; i++) begin : g_shuf
        localparam int SH = omega_pkg::shuffle_pos(i, A);
        assign shuf[SH*PW +: PW] = lines_i[i*PW +: PW];
    end

    for (genvar e = 0; e < NE; e++) begin : g_elem
        omega_elem #(
            .A      (A),
            .W      (W),
            .BITSEL (A - 1 - STG)
        ) u_elem (
            .pk_up    (shuf[(2*e)*PW +: PW]),
            .pk_dn    (shuf[(2*e+1)*PW +: PW]),
            .q_up     (lines_o[(2*e)*PW +: PW]),
            .q_dn     (lines_o[(2*e+1)*PW +: PW]),
            .lose     (lose[e]),
            .lose_src (lose_src[e])
        );
    end

    always_comb begin
        blk_o = '0;
        for (int e = 0; e < NE; e++) begin
            if (lose[e]) blk_o[lose_src[e]] = 1'b1;
        end
    end

endmodule

// File: rtl/omega_route_net.sv
module omega_route_net #(
    parameter int A  = 3,
    parameter int W  = 8,
    localparam int N = 1 << A
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0]   in_vld,
    input  logic [N*A-1:0] in_dest,
    input  logic [N*W-1:0] in_data,
    output logic [N-1:0]   out_vld,
    output logic [N*A-1:0] out_src,
    output logic [N*W-1:0] out_data,
    output logic [N-1:0]   in_blk
);
    localparam int PW = 1 + 2 * A + W;

    typedef struct packed {
        logic [N-1:0]   vld;
        logic [N*A-1:0] src;
        logic [N*W-1:0] dat;
        logic [N-1:0]   blk;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic [A:0][N*PW-1:0] link;
    logic [A-1:0][N-1:0]  stg_blk;

    for (genvar i = 0; i < N; i++) begin : g_pack
        assign link[0][i*PW +: PW] =
            {in_vld[i], in_dest[i*A +: A], A'(i), in_data[i*W +: W]};
    end

    for (genvar s = 0; s < A; s++) begin : g_stage
        omega_stage #(
            .A   (A),
            .W   (W),
            .STG (s)
        ) u_stage (
            .lines_i (link[s]),
            .lines_o (link[s+1]),
            .blk_o   (stg_blk[s])
        );
    end

    always_comb begin
        st_d = '0;
        for (int s = 0; s < A; s++) begin
            st_d.blk = st_d.blk | stg_blk[s];
        end
        for (int j = 0; j < N; j++) begin
            if (link[A][j*PW + PW - 1]) begin
                st_d.vld[j]         = 1'b1;
                st_d.src[j*A +: A]  = link[A][j*PW + W +: A];
                st_d.dat[j*W +: W]  = link[A][j*PW +: W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_vld  = st_q.vld;
    assign out_src  = st_q.src;
    assign out_data = st_q.dat;
    assign in_blk   = st_q.blk;

endmodule

// File: rtl/omega_route_chk.sv
module omega_route_chk #(
    parameter int A  = 3,
    parameter int W  = 8,
    localparam int N = 1 << A
) (
    input logic           clk,
    input logic           rst,
    input logic [N-1:0]   in_vld,
    input logic [N*A-1:0] in_dest,
    input logic [N*W-1:0] in_data,
    input logic [N-1:0]   out_vld,
    input logic [N*A-1:0] out_src,
    input logic [N*W-1:0] out_data,
    input logic [N-1:0]   in_blk
);
    logic [N-1:0]   vld_p;
    logic [N*A-1:0] dst_p;
    logic [N*W-1:0] dat_p;
    logic           armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            vld_p <= '0;
            dst_p <= '0;
            dat_p <= '0;
        end else begin
            armed <= 1'b1;
            vld_p <= in_vld;
            dst_p <= in_dest;
            dat_p <= in_data;
        end
    end

    // R8: every valid packet is either delivered or flagged blocked.
    a_r8_conserve: assert property (@(posedge clk) disable iff (rst)
        armed |-> ($countones(out_vld) + $countones(in_blk) == $countones(vld_p)));

    // R8: only ports that offered a packet may be flagged.
    a_r8_blk_valid: assert property (@(posedge clk) disable iff (rst)
        armed |-> ((in_blk & ~vld_p) == '0));

    // R7: no offered packets, nothing delivered.
    a_r7_idle: assert property (@(posedge clk) disable iff (rst)
        (armed && vld_p == '0) |-> (out_vld == '0));

    for (genvar j = 0; j < N; j++) begin : g_port
        logic [A-1:0] sj;
        assign sj = out_src[j*A +: A];

        // R2: delivered packet came from its source port with matching tag and payload.
        a_r2_route: assert property (@(posedge clk) disable iff (rst)
            (armed && out_vld[j]) |->
                (vld_p[sj] && dst_p[sj*A +: A] == A'(j) && dat_p[sj*W +: W] == out_data[j*W +: W]));

        // R7: empty outputs carry zero fields.
        a_r7_empty_zero: assert property (@(posedge clk) disable iff (rst)
            !out_vld[j] |-> (sj == '0 && out_data[j*W +: W] == '0));
    end

endmodule

bind omega_route_net omega_route_chk #(.A(A), .W(W)) u_chk (.*);

// File: tb/tb_omega_route_net.sv
`timescale 1ns/1ps
module tb_omega_route_net;

    localparam int A = 3;
    localparam int W = 8;
    localparam int N = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [N-1:0]   in_vld  = '0;
    logic [N*A-1:0] in_dest = '0;
    logic [N*W-1:0] in_data = '0;
    logic [N-1:0]   out_vld;
    logic [N*A-1:0] out_src;
    logic [N*W-1:0] out_data;
    logic [N-1:0]   in_blk;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [N-1:0]   vld;
        logic [N*A-1:0] src;
        logic [N*W-1:0] dat;
        logic [N-1:0]   blk;
        string          tag;
    } exp_t;

    exp_t sb_q[$];

    always #4 clk = ~clk;

    omega_route_net #(.A(A), .W(W)) dut (
        .clk      (clk),
        .rst      (rst),
        .in_vld   (in_vld),
        .in_dest  (in_dest),
        .in_data  (in_data),
        .out_vld  (out_vld),
        .out_src  (out_src),
        .out_data (out_data),
        .in_blk   (in_blk)
    );

    function automatic int rot3(input int x);
        return ((x << 1) | (x >> 2)) & 7;
    endfunction

    // Reference: walk packets column by column; even (upper) lines claim first.
    function automatic exp_t model(input logic [N-1:0] v, input logic [N*A-1:0] d,
                                   input logic [N*W-1:0] dat, input string tag);
        exp_t e;
        int   pos[N];
        int   nxt[N];
        bit   live[N];
        int   owner[N];
        e.vld = '0; e.src = '0; e.dat = '0; e.blk = '0; e.tag = tag;
        for (int p = 0; p < N; p++) begin
            live[p] = v[p];
            pos[p]  = p;
            nxt[p]  = p;
        end
        for (int s = 0; s < A; s++) begin
            for (int t = 0; t < N; t++) owner[t] = -1;
            for (int l = 0; l < N; l++) begin
                for (int p = 0; p < N; p++) begin
                    if (live[p] && rot3(pos[p]) == l) begin
                        int tgt;
                        tgt = (l & 6) | int'(d[p*A + (A-1-s)]);
                        if (owner[tgt] < 0) begin
                            owner[tgt] = p;
                            nxt[p] = tgt;
                        end else begin
                            live[p]  = 1'b0;
                            e.blk[p] = 1'b1;
                        end
                    end
                end
            end
            for (int p = 0; p < N; p++) pos[p] = nxt[p];
        end
        for (int p = 0; p < N; p++) begin
            if (live[p]) begin
                e.vld[pos[p]]            = 1'b1;
                e.src[pos[p]*A +: A]     = A'(p);
                e.dat[pos[p]*W +: W]     = dat[p*W +: W];
            end
        end
        return e;
    endfunction

    task automatic drive(input logic [N-1:0] v, input logic [N*A-1:0] d,
                         input logic [N*W-1:0] dat, input string tag);
        @(negedge clk);
        in_vld  = v;
        in_dest = d;
        in_data = dat;
        sb_q.push_back(model(v, d, dat, tag));
    endtask

    task automatic chk(input string req, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (%s): actual %0h expected %0h", req, tag, act, exp);
        end
    endtask

    // Monitor: one result per driven vector, one clock later.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (!rst && sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                chk("R2 out_vld", e.tag, 64'(out_vld), 64'(e.vld));
                chk("R8 in_blk", e.tag, 64'(in_blk), 64'(e.blk));
                for (int j = 0; j < N; j++) begin
                    if (e.vld[j]) begin
                        chk("R2 src", e.tag, 64'(out_src[j*A +: A]), 64'(e.src[j*A +: A]));
                        chk("R2 data", e.tag, 64'(out_data[j*W +: W]), 64'(e.dat[j*W +: W]));
                    end else begin
                        chk("R7 empty fields", e.tag,
                            64'({out_src[j*A +: A], out_data[j*W +: W]}), 64'(0));
                    end
                end
            end
        end
    end

    function automatic logic [N*W-1:0] mk_data(input int seed);
        logic [N*W-1:0] r;
        for (int i = 0; i < N; i++) r[i*W +: W] = W'(seed * 17 + i * 29 + 3);
        return r;
    endfunction

    task automatic run_all();
        logic [N*A-1:0] d;
        logic [31:0]    lf;
        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        chk("R1 reset out_vld", "reset", 64'(out_vld), 64'(0));
        chk("R1 reset in_blk", "reset", 64'(in_blk), 64'(0));
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #2;
        chk("R1 after reset out_vld", "post", 64'(out_vld), 64'(0));
        chk("R1 after reset in_blk", "post", 64'(in_blk), 64'(0));

        // R3: lone packet 4 -> 6
        d = '0; d[4*A +: A] = 3'd6;
        drive(8'b0001_0000, d, mk_data(1), "R3 path 4to6");

        // R4: every cyclic shift passes unblocked
        for (int k = 0; k < N; k++) begin
            for (int i = 0; i < N; i++) d[i*A +: A] = A'((i + k) % N);
            drive(8'hFF, d, mk_data(10 + k), $sformatf("R4 shift %0d", k));
        end

        // R5: ports 0 and 4 both to tag 0, upper (port 0) wins
        d = '0;
        drive(8'b0001_0001, d, mk_data(30), "R5 upper wins");

        // R6: ports 0->0 and 4->1 collide in column 0
        d = '0; d[4*A +: A] = 3'd1;
        drive(8'b0001_0001, d, mk_data(31), "R6 differ tags block");
        // R8: retry of blocked port 4 alone
        drive(8'b0001_0000, d, mk_data(32), "R8 retry");

        // R7: no valid inputs, tags and data set but ignored
        for (int i = 0; i < N; i++) d[i*A +: A] = A'(N - 1 - i);
        drive(8'h00, d, mk_data(33), "R7 all invalid");

        // Mixed traffic
        lf = 32'h1D2C_3B4A;
        for (int n = 0; n < 300; n++) begin
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            d = lf[N*A-1:0];
            drive(lf[31:24] | lf[7:0], d, mk_data(n + 40), "R8 mixed");
        end

        @(negedge clk);
        in_vld = '0;
        repeat (4) @(posedge clk);
        #3;
        chk("R8 scoreboard drained", "end", 64'(sb_q.size()), 64'(0));
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule